// File: doc/BRIEF.md
# Advanced Load Check Table

This block lets a core hoist loads above older stores whose addresses are not yet known to differ. When such an early load issues, the core records the destination register and the load address in a small, fully associative table. Every store that retires afterwards is compared against all recorded addresses, and any record whose 8-byte block matches is invalidated. The aliasing is not prevented. It is only noted, so that it can be caught later.

At the original program position of the load, the core issues a check for the destination register. There are two kinds of check. A reload check reports whether the early value must be fetched again. A branch check reports whether control must go to a recovery sequence. A register with no record, or with an invalidated record, always fails its check. The memory access, the reload itself and the recovery code are outside this block.

The table holds 16 records by default. A new early load goes into one of three places, in this order of preference:
- the record already tagged with the same register;
- the lowest free slot;
- a round-robin victim, when every slot is in use.

Top module: `specLoadTable`

## Requirements
- R1: While `rstN` is low every record becomes invalid, and `respValid`, `respReload` and `respRecover` are 0.
- R2: A store with `stValid` = 1 invalidates every record whose address matches `stAddr` in bits [63:3] (same 8-byte block). A record in a different block stays valid.
- R3: A check with `chkValid` = 1 and `chkKind` = 0 (reload check) gives `respValid` = 1 in the next cycle. `respReload` is 0 if a valid record for `chkReg` exists and 1 otherwise. `respRecover` is 0.
- R4: A check with `chkKind` = 1 (branch check) gives `respValid` = 1 in the next cycle. `respRecover` is 0 if a valid record for `chkReg` exists and 1 otherwise. `respReload` is 0.
- R5: A register that never had a record is treated as invalid on check.
- R6: A check sees a store issued in the same cycle. It does not see an early-load insert issued in the same cycle.
- R7: When a store and an early-load insert fall in the same cycle, the invalidation is applied first, so the new record is valid even when its block matches the store.
- R8: An early load to a register that already has a valid record overwrites that record. No second record is made.
- R9: Otherwise a new record takes the lowest-index free slot, where freeing by a same-cycle store counts.
- R10: When all slots are valid, a new record replaces a round-robin victim. The victim starts at slot 0 after reset and advances by one per replacement, wrapping at the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Early load issued this cycle |
| ldReg | input | 7 | Destination register of the early load |
| ldAddr | input | 64 | Address of the early load |
| stValid | input | 1 | Store issued this cycle |
| stAddr | input | 64 | Address of the store |
| chkValid | input | 1 | Check issued this cycle |
| chkKind | input | 1 | 0 = reload check, 1 = branch check |
| chkReg | input | 7 | Register being checked |
| respValid | output | 1 | Check response valid (one cycle after the check) |
| respReload | output | 1 | Reload check failed: the value must be reloaded |
| respRecover | output | 1 | Branch check failed: go to recovery |

## Verification
A store and an early-load insert can land in the same cycle, and a check can share a cycle with either of them. The stimulus table includes the following cases:
- a store and an insert to the same block in one cycle, followed by a check that must pass;
- a store paired with a check of the register whose record it kills, where the check must fail;
- an insert paired with a check of the very register being inserted, where the check must still fail.

A directed sequence fills all slots and then frees one with a store. It then shows that the next insert takes the freed slot and the following insert takes the round-robin victim. Each check response is compared with a value worked out by hand from the requirements.

// File: rtl/sltPkg.sv
package sltPkg;
  // widest slot index the strobe can carry (up to 256 entries)
  localparam int unsigned IDX_MAX_W = 8;

  typedef struct packed {
    logic                 storeKill;  // apply store invalidation this cycle
    logic                 insert;     // write a record this cycle
    logic [IDX_MAX_W-1:0] insIdx;     // slot written by the insert
  } sltStrobe_t;
endpackage

// File: rtl/sltEntryArray.sv
module sltEntryArray
  import sltPkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned REG_W   = 7,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned ALIGN_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  sltStrobe_t         strobe,
  input  logic [REG_W-1:0]   ldReg,
  input  logic [ADDR_W-1:0]  ldAddr,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic [REG_W-1:0]   chkReg,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] tagHitVec,
  output logic [ENTRIES-1:0] storeHitVec,
  output logic [ENTRIES-1:0] chkHitVec
);
  localparam int unsigned BLK_W = ADDR_W - ALIGN_W;

  logic [BLK_W-1:0] stBlk;
  logic [BLK_W-1:0] ldBlk;
  assign stBlk = stAddr[ADDR_W-1:ALIGN_W];
  assign ldBlk = ldAddr[ADDR_W-1:ALIGN_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : gSlot
    logic             validQ;
    logic [REG_W-1:0] tagQ;
    logic [BLK_W-1:0] blkQ;
    logic             wrHere;

    assign wrHere         = strobe.insert && (strobe.insIdx == IDX_MAX_W'(i));
    assign validVec[i]    = validQ;
    assign tagHitVec[i]   = validQ && (tagQ == ldReg);
    assign storeHitVec[i] = validQ && (blkQ == stBlk);
    // a same-cycle store is older than the check, so it counts
    assign chkHitVec[i]   = validQ && (tagQ == chkReg) &&
                            !(strobe.storeKill && storeHitVec[i]);

    // insert has priority: invalidation is logically applied first
    always_ff @(posedge clk) begin
      if (!rstN)                                     validQ <= 1'b0;
      else if (wrHere)                               validQ <= 1'b1;
      else if (strobe.storeKill && storeHitVec[i])   validQ <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        tagQ <= ldReg;
        blkQ <= ldBlk;
      end
    end
  end
endmodule

// File: rtl/sltControl.sv
module sltControl
  import sltPkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic               stValid,
  input  logic               chkValid,
  input  logic               chkKind,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] tagHitVec,
  input  logic [ENTRIES-1:0] storeHitVec,
  input  logic [ENTRIES-1:0] chkHitVec,
  output sltStrobe_t         strobe,
  output logic               respValid,
  output logic               respReload,
  output logic               respRecover
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] killMask;
  logic [ENTRIES-1:0] postValid;
  logic [IDX_W-1:0]   tagIdx;
  logic [IDX_W-1:0]   freeIdx;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   rrPtr;
  logic               tagHit;
  logic               full;
  logic               replace;
  logic               chkHit;

  always_comb begin
    killMask  = stValid ? storeHitVec : '0;
    postValid = validVec & ~killMask;
    tagHit    = |tagHitVec;
    full      = &postValid;
    chkHit    = |chkHitVec;
    tagIdx    = '0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tagHitVec[i])  tagIdx  = IDX_W'(i);
      if (!postValid[i]) freeIdx = IDX_W'(i);   // lowest index wins
    end
    if (tagHit)     victim = tagIdx;
    else if (!full) victim = freeIdx;
    else            victim = rrPtr;
    replace          = ldValid && !tagHit && full;
    strobe.storeKill = stValid;
    strobe.insert    = ldValid;
    strobe.insIdx    = IDX_MAX_W'(victim);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        rrPtr <= '0;
    else if (replace) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respReload  <= 1'b0;
      respRecover <= 1'b0;
    end else begin
      respValid   <= chkValid;
      respReload  <= chkValid && !chkKind && !chkHit;
      respRecover <= chkValid &&  chkKind && !chkHit;
    end
  end
endmodule

// File: rtl/specLoadTable.sv
module specLoadTable
  import sltPkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned REG_W   = 7,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned ALIGN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              chkValid,
  input  logic              chkKind,
  input  logic [REG_W-1:0]  chkReg,
  output logic              respValid,
  output logic              respReload,
  output logic              respRecover
);
  sltStrobe_t         strobe;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] tagHitVec;
  logic [ENTRIES-1:0] storeHitVec;
  logic [ENTRIES-1:0] chkHitVec;

  sltEntryArray #(
    .ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)
  ) uArray (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldReg(ldReg), .ldAddr(ldAddr), .stAddr(stAddr), .chkReg(chkReg),
    .validVec(validVec), .tagHitVec(tagHitVec),
    .storeHitVec(storeHitVec), .chkHitVec(chkHitVec)
  );

  sltControl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .stValid(stValid),
    .chkValid(chkValid), .chkKind(chkKind),
    .validVec(validVec), .tagHitVec(tagHitVec),
    .storeHitVec(storeHitVec), .chkHitVec(chkHitVec),
    .strobe(strobe), .respValid(respValid),
    .respReload(respReload), .respRecover(respRecover)
  );
endmodule

// File: rtl/sltChecker.sv
module sltChecker
  import sltPkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 chkValid,
  input logic                 chkKind,
  input logic                 respValid,
  input logic                 respReload,
  input logic                 respRecover,
  input logic                 insert,
  input logic [IDX_MAX_W-1:0] insIdx
);
  // R3
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> respValid);

  // R1
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> (!respValid && !respReload && !respRecover));

  // R4
  recover_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    respRecover |-> $past(chkKind));

  // R3
  reload_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    respReload |-> !$past(chkKind));

  // R10
  victim_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    insert |-> (insIdx < IDX_MAX_W'(ENTRIES)));
endmodule

bind specLoadTable sltChecker #(.ENTRIES(ENTRIES)) uChecker (
  .clk(clk), .rstN(rstN), .chkValid(chkValid), .chkKind(chkKind),
  .respValid(respValid), .respReload(respReload), .respRecover(respRecover),
  .insert(strobe.insert), .insIdx(strobe.insIdx)
);

// File: tb/specLoadTable_test.sv
module specLoadTable_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        ldValid, stValid, chkValid, chkKind;
  logic [6:0]  ldReg, chkReg;
  logic [63:0] ldAddr, stAddr;
  logic        respValid, respReload, respRecover;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;   // 50 MHz

  specLoadTable uut (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldReg(ldReg), .ldAddr(ldAddr),
    .stValid(stValid), .stAddr(stAddr),
    .chkValid(chkValid), .chkKind(chkKind), .chkReg(chkReg),
    .respValid(respValid), .respReload(respReload), .respRecover(respRecover)
  );

  typedef struct packed {
    logic        ld;
    logic [6:0]  lReg;
    logic [63:0] lAddr;
    logic        st;
    logic [63:0] sAddr;
    logic        chk;
    logic        kind;
    logic [6:0]  cReg;
    logic [2:0]  exp;    // {respValid, respReload, respRecover}
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R3: record r5 at 0x1000
    '{1'b1, 7'd5,  64'h1000, 1'b0, 64'h0,    1'b0, 1'b0, 7'd0,  3'b000, 8'd3},
    // R3: reload check on valid record
    '{1'b0, 7'd0,  64'h0,    1'b0, 64'h0,    1'b1, 1'b0, 7'd5,  3'b100, 8'd3},
    // R4: branch check on valid record
    '{1'b0, 7'd0,  64'h0,    1'b0, 64'h0,    1'b1, 1'b1, 7'd5,  3'b100, 8'd4},
    // R6 / R2: store into same 8-byte block, checked in the same cycle
    '{1'b0, 7'd0,  64'h0,    1'b1, 64'h1004, 1'b1, 1'b0, 7'd5,  3'b110, 8'd6},
    // R4: branch check on killed record
    '{1'b0, 7'd0,  64'h0,    1'b0, 64'h0,    1'b1, 1'b1, 7'd5,  3'b101, 8'd4},
    // R5: register never recorded
    '{1'b0, 7'd0,  64'h0,    1'b0, 64'h0,    1'b1, 1'b0, 7'd9,  3'b110, 8'd5},
    // R7: store and insert to the same block together
    '{1'b1, 7'd9,  64'h2000, 1'b1, 64'h2000, 1'b0, 1'b0, 7'd0,  3'b000, 8'd7},
    // R7: the new record survived
    '{1'b0, 7'd0,  64'h0,    1'b0, 64'h0,    1'b1, 1'b0, 7'd9,  3'b100, 8'd7},
    // R2: store to the neighbouring block leaves r9 alone
    '{1'b0, 7'd0,  64'h0,    1'b1, 64'h2008, 1'b1, 1'b1, 7'd9,  3'b100, 8'd2},
    // R6: check does not see a same-cycle insert
    '{1'b1, 7'd11, 64'h4000, 1'b0, 64'h0,    1'b1, 1'b0, 7'd11, 3'b110, 8'd6},
    // R8: re-record r9 at a new address
    '{1'b1, 7'd9,  64'h3000, 1'b0, 64'h0,    1'b0, 1'b0, 7'd0,  3'b000, 8'd8},
    // R8: store to the new address kills the only r9 record
    '{1'b0, 7'd0,  64'h0,    1'b1, 64'h3000, 1'b1, 1'b0, 7'd9,  3'b110, 8'd8},
    // R6: insert of r11 took effect one cycle later
    '{1'b0, 7'd0,  64'h0,    1'b0, 64'h0,    1'b1, 1'b1, 7'd11, 3'b100, 8'd6}
  };

  task automatic doCycle(input logic ld, input logic [6:0] lr, input logic [63:0] la,
                         input logic st, input logic [63:0] sa,
                         input logic ck, input logic kd, input logic [6:0] cr);
    ldValid = ld; ldReg = lr; ldAddr = la;
    stValid = st; stAddr = sa;
    chkValid = ck; chkKind = kd; chkReg = cr;
    @(negedge clk);
  endtask

  task automatic idle();
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 7'd0);
  endtask

  task automatic expectResp(input logic [2:0] exp, input string req);
    checkCount++;
    if ({respValid, respReload, respRecover} !== exp) begin
      failCount++;
      $display("FAIL %s: resp {valid,reload,recover} = %b expected %b", req,
               {respValid, respReload, respRecover}, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    ldValid = 0; stValid = 0; chkValid = 0; chkKind = 0;
    ldReg = 0; chkReg = 0; ldAddr = 0; stAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet outputs after reset
    expectResp(3'b000, "R1");
    // R1: table empty after reset
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd5);
    expectResp(3'b110, "R1");

    for (int i = 0; i < NV; i++) begin
      doCycle(VECS[i].ld, VECS[i].lReg, VECS[i].lAddr, VECS[i].st, VECS[i].sAddr,
              VECS[i].chk, VECS[i].kind, VECS[i].cReg);
      expectResp(VECS[i].exp, $sformatf("R%0d (vector %0d)", VECS[i].req, i));
    end

    // R1: reset mid-run clears r11
    rstN = 1'b0;
    idle(); idle();
    rstN = 1'b1;
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b1, 7'd11);
    expectResp(3'b101, "R1");

    // R9: fill slots 0..15 with r0..r15
    for (int i = 0; i < 16; i++)
      doCycle(1'b1, 7'(i), 64'(i) * 64'h100, 1'b0, 64'h0, 1'b0, 1'b0, 7'd0);
    // R10: full, r20 replaces slot 0 (r0)
    doCycle(1'b1, 7'd20, 64'h5000, 1'b0, 64'h0, 1'b0, 1'b0, 7'd0);
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd0);
    expectResp(3'b110, "R10 r0 evicted");
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd1);
    expectResp(3'b100, "R10 r1 kept");
    // R10: next victim is slot 1 (r1)
    doCycle(1'b1, 7'd21, 64'h5100, 1'b0, 64'h0, 1'b0, 1'b0, 7'd0);
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd1);
    expectResp(3'b110, "R10 r1 evicted");
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd2);
    expectResp(3'b100, "R10 r2 kept");
    // R2: store kills r5 (slot 5)
    doCycle(1'b0, 7'd0, 64'h0, 1'b1, 64'h500, 1'b0, 1'b0, 7'd0);
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b1, 7'd5);
    expectResp(3'b101, "R2 r5 killed");
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b1, 7'd4);
    expectResp(3'b100, "R2 r4 kept");
    // R9: r22 takes freed slot 5, then r23 takes victim slot 2 (r2)
    doCycle(1'b1, 7'd22, 64'h6000, 1'b0, 64'h0, 1'b0, 1'b0, 7'd0);
    doCycle(1'b1, 7'd23, 64'h7000, 1'b0, 64'h0, 1'b0, 1'b0, 7'd0);
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd22);
    expectResp(3'b100, "R9 r22 present");
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd3);
    expectResp(3'b100, "R9 r3 kept");
    doCycle(1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 7'd2);
    expectResp(3'b110, "R10 r2 evicted");
    idle();
    expectResp(3'b000, "R3 no check no response");

    summary();
    $finish;
  end
endmodule